// File: doc/BRIEF.md
# Region-Aware Erase Range Walker

This block takes an erase request, given as a start byte address and a byte length, and turns it into a series of single-block erase commands for a downstream erase sequencer. The flash map it works against has two regions. The lower region starts at address zero and uses small blocks. The upper region follows it directly and uses large blocks. Both regions are fixed by parameters.

First the block validates the request. The request must fit inside the device. The start address must sit on a block boundary of the region that contains it. The end address must sit on a block boundary of the region that contains the end. If the request passes, the block walks from the start to the end one block at a time. It switches to the large step size once the walk reaches the end of the lower region. Only one erase is outstanding at any time. Each erase command is offered on a valid/ready handshake, and the block then waits for a completion pulse that carries a failure flag. Every accepted request ends with exactly one one-cycle result pulse: done, invalid or failed.

The controller is a five-state machine:
- IDLE accepts a request and moves to CHECK.
- CHECK moves to REPORT with an invalid result for a bad request, or to REPORT with done for an empty request. Otherwise it moves to ISSUE.
- ISSUE holds the command until it is accepted, then moves to WAIT.
- WAIT returns to ISSUE after a good completion that still leaves length to erase. It moves to REPORT with done after the good completion of the last block, and to REPORT with failed after a failed completion.
- REPORT drives the result pulse and returns to IDLE.

Top module: `erase_range_walker`

## Requirements
- R1: The map has two regions. The lower region runs from 0 and holds R0_NBLK blocks of R0_BLK bytes each. The upper region starts at R0_BLK*R0_NBLK and holds R1_NBLK blocks of R1_BLK bytes each. The device size is the sum of both regions. Block sizes are powers of two, and the upper offset is a multiple of R1_BLK.
- R2: A request whose start plus length is greater than the device size gives an invalid pulse and issues no erase command.
- R3: The start belongs to the upper region when it is at or above the upper offset, and to the lower region otherwise. A start that is not a multiple of its region's block size gives an invalid pulse and issues no erase command.
- R4: The end (start plus length) belongs to the upper region when it is at or above the upper offset; an end exactly on the offset therefore counts as upper. An end that is not a multiple of that region's block size gives an invalid pulse and issues no erase command.
- R5: For a valid request of nonzero length, erase commands go out in ascending order, each carrying the first byte address of its block. The first command is at the start. Each following address is the previous one plus the block size of the previous block's region, and the step becomes R1_BLK once the address reaches the upper offset. No command reaches the end address.
- R6: A command holds `ers_valid` and a steady `ers_addr` until `ers_ready`. After acceptance no further command is offered until a completion pulse arrives. A completion pulse that arrives while no erase is outstanding is ignored.
- R7: A completion that carries `cmp_fail=1` produces a fail pulse, and no further erase command is issued for that request.
- R8: After the good completion of the last block, a done pulse follows and no further erase command is issued.
- R9: A zero-length request still goes through checks R2 to R4. If it passes, it gives a done pulse and issues no erase command.
- R10: `req_ready` is high only when the block is idle, and a request is taken on a cycle where `req_valid` and `req_ready` are both high. Requests offered while busy are not taken. Each taken request gives exactly one one-cycle pulse on one of `done_pulse`, `invalid_pulse` or `fail_pulse`. For an invalid or zero-length request, the pulse is present during the second cycle after the acceptance edge.
- R11: After reset, `req_ready` is high and `ers_valid` and all three result pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Erase request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_start | input | ADDR_W | Start byte address of the range |
| req_len | input | ADDR_W | Byte length of the range |
| ers_valid | output | 1 | Block erase command offered |
| ers_ready | input | 1 | Sequencer accepts the command |
| ers_addr | output | ADDR_W | First byte address of the block to erase |
| cmp_valid | input | 1 | Completion pulse for the outstanding erase |
| cmp_fail | input | 1 | Completion reports a failed erase |
| done_pulse | output | 1 | Request finished successfully |
| invalid_pulse | output | 1 | Request rejected by the checks |
| fail_pulse | output | 1 | An erase failed and the walk stopped |

## Verification
Two events can fall on the same completion edge. One is the step-size switch at the end of the lower region. The other is the decision that the remaining length is used up. Both happen when a range ends exactly on the region offset or on the device end. A sweep over every start and length of a small map provokes these cases, along with failures on the block that crosses the boundary. The bench judges each case by the exact list of erase addresses, the count of commands and the kind of result. Spurious completions that carry a failure are injected while a command is still waiting for acceptance, to show that they are ignored.

// File: rtl/erw_pkg.sv
package erw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_ISSUE  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_REPORT = 3'd4
    } erw_state_e;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_DONE = 2'd1,
        RES_BAD  = 2'd2,
        RES_FAIL = 2'd3
    } erw_res_e;

endpackage

// File: rtl/erw_region_lookup.sv
// Decides which region an address falls in and whether it sits on a block edge.
module erw_region_lookup #(
    parameter int XW      = 25,
    parameter int R0_BLK  = 16384,
    parameter int R0_NBLK = 8,
    parameter int R1_BLK  = 131072
) (
    input  logic [XW-1:0] addr,
    output logic          in_upper,
    output logic          aligned
);
    localparam logic [XW-1:0] BOUND  = XW'(R0_BLK * R0_NBLK);
    localparam logic [XW-1:0] MSK_LO = XW'(R0_BLK - 1);
    localparam logic [XW-1:0] MSK_HI = XW'(R1_BLK - 1);

    always_comb begin
        in_upper = (addr >= BOUND);
        aligned  = ((addr & (in_upper ? MSK_HI : MSK_LO)) == '0);
    end
endmodule

// File: rtl/erw_req_check.sv
// Combinational request validation: range, start alignment, end alignment.
module erw_req_check #(
    parameter int XW      = 25,
    parameter int R0_BLK  = 16384,
    parameter int R0_NBLK = 8,
    parameter int R1_BLK  = 131072,
    parameter int R1_NBLK = 31
) (
    input  logic [XW-1:0] start_x,
    input  logic [XW-1:0] len_x,
    output logic          ok,
    output logic          is_empty,
    output logic          start_upper
);
    localparam logic [XW-1:0] TOTAL = XW'(R0_BLK * R0_NBLK + R1_BLK * R1_NBLK);
    localparam int NPROBE = 2;

    logic [NPROBE-1:0][XW-1:0] probe;
    logic [NPROBE-1:0]         upper;
    logic [NPROBE-1:0]         on_edge;

    assign probe[0] = start_x;
    assign probe[1] = start_x + len_x;

    for (genvar g = 0; g < NPROBE; g++) begin : g_probe
        erw_region_lookup #(
            .XW(XW), .R0_BLK(R0_BLK), .R0_NBLK(R0_NBLK), .R1_BLK(R1_BLK)
        ) i_lookup (
            .addr    (probe[g]),
            .in_upper(upper[g]),
            .aligned (on_edge[g])
        );
    end

    always_comb begin
        // the end region is searched from the start region onward
        ok          = (probe[1] <= TOTAL) && on_edge[0] && on_edge[1]
                      && (upper[1] || !upper[0]);
        is_empty    = (len_x == '0);
        start_upper = upper[0];
    end
endmodule

// File: rtl/erw_block_stepper.sv
// Walk registers: current block address, remaining bytes, current region.
module erw_block_stepper #(
    parameter int XW      = 25,
    parameter int R0_BLK  = 16384,
    parameter int R0_NBLK = 8,
    parameter int R1_BLK  = 131072
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [XW-1:0] start_x,
    input  logic [XW-1:0] len_x,
    input  logic          start_upper,
    input  logic          advance,
    output logic [XW-1:0] cur_x,
    output logic [XW-1:0] blk_x,
    output logic          last
);
    localparam logic [XW-1:0] BOUND  = XW'(R0_BLK * R0_NBLK);
    localparam logic [XW-1:0] BLK_LO = XW'(R0_BLK);
    localparam logic [XW-1:0] BLK_HI = XW'(R1_BLK);

    logic [XW-1:0] cur_q, rem_q, cur_nx;
    logic          upper_q;

    always_comb begin
        blk_x  = upper_q ? BLK_HI : BLK_LO;
        cur_nx = cur_q + blk_x;
        last   = (rem_q == blk_x);
        cur_x  = cur_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            rem_q   <= '0;
            upper_q <= 1'b0;
        end else if (load) begin
            cur_q   <= start_x;
            rem_q   <= len_x;
            upper_q <= start_upper;
        end else if (advance) begin
            cur_q <= cur_nx;
            rem_q <= rem_q - blk_x;
            if (!upper_q && cur_nx == BOUND) begin
                upper_q <= 1'b1;
            end
        end
    end

    AST_STEP_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (rem_q >= blk_x)); // R5
    AST_REGION_NO_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
        (upper_q && !load) |=> upper_q); // R5
endmodule

// File: rtl/erase_range_walker.sv
module erase_range_walker
    import erw_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int R0_BLK  = 16384,
    parameter int R0_NBLK = 8,
    parameter int R1_BLK  = 131072,
    parameter int R1_NBLK = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_len,
    output logic              ers_valid,
    input  logic              ers_ready,
    output logic [ADDR_W-1:0] ers_addr,
    input  logic              cmp_valid,
    input  logic              cmp_fail,
    output logic              done_pulse,
    output logic              invalid_pulse,
    output logic              fail_pulse
);
    localparam int XW = ADDR_W + 1;

    erw_state_e    state_q, state_d;
    erw_res_e      res_q, res_d;
    logic [XW-1:0] start_q, len_q;
    logic          chk_ok, chk_empty, chk_upper;
    logic [XW-1:0] cur_x, blk_x;
    logic          last_blk, step_load, step_adv;
    logic          issued_q;

    erw_req_check #(
        .XW(XW), .R0_BLK(R0_BLK), .R0_NBLK(R0_NBLK), .R1_BLK(R1_BLK), .R1_NBLK(R1_NBLK)
    ) i_check (
        .start_x    (start_q),
        .len_x      (len_q),
        .ok         (chk_ok),
        .is_empty   (chk_empty),
        .start_upper(chk_upper)
    );

    assign step_load = (state_q == ST_CHECK);
    assign step_adv  = (state_q == ST_WAIT) && cmp_valid && !cmp_fail;

    erw_block_stepper #(
        .XW(XW), .R0_BLK(R0_BLK), .R0_NBLK(R0_NBLK), .R1_BLK(R1_BLK)
    ) i_stepper (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (step_load),
        .start_x    (start_q),
        .len_x      (len_q),
        .start_upper(chk_upper),
        .advance    (step_adv),
        .cur_x      (cur_x),
        .blk_x      (blk_x),
        .last       (last_blk)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= RES_NONE;
            start_q <= '0;
            len_q   <= '0;
        end else begin
            res_q <= res_d;
            if (req_valid && req_ready) begin
                start_q <= {1'b0, req_start};
                len_q   <= {1'b0, req_len};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       issued_q <= 1'b0;
        else if (state_q == ST_IDLE)      issued_q <= 1'b0;
        else if (ers_valid && ers_ready)  issued_q <= 1'b1;
    end

    // next state and result
    always_comb begin
        state_d = state_q;
        res_d   = res_q;
        unique case (state_q)
            ST_IDLE: begin
                res_d = RES_NONE;
                if (req_valid) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (!chk_ok) begin
                    state_d = ST_REPORT;
                    res_d   = RES_BAD;
                end else if (chk_empty) begin
                    state_d = ST_REPORT;
                    res_d   = RES_DONE;
                end else begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (ers_ready) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (cmp_valid) begin
                    if (cmp_fail) begin
                        state_d = ST_REPORT;
                        res_d   = RES_FAIL;
                    end else if (last_blk) begin
                        state_d = ST_REPORT;
                        res_d   = RES_DONE;
                    end else begin
                        state_d = ST_ISSUE;
                    end
                end
            end
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        ers_valid     = (state_q == ST_ISSUE);
        ers_addr      = cur_x[ADDR_W-1:0];
        done_pulse    = (state_q == ST_REPORT) && (res_q == RES_DONE);
        invalid_pulse = (state_q == ST_REPORT) && (res_q == RES_BAD);
        fail_pulse    = (state_q == ST_REPORT) && (res_q == RES_FAIL);
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_pulse, invalid_pulse, fail_pulse})); // R10
    AST_OUTCOME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse || invalid_pulse || fail_pulse) |=> !(done_pulse || invalid_pulse || fail_pulse)); // R10
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ers_valid && !ers_ready) |=> (ers_valid && $stable(ers_addr))); // R6
    AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !ers_valid); // R6
    AST_BAD_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_pulse |-> !issued_q); // R2
    AST_CMD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ers_valid |-> ((cur_x + blk_x) <= (start_q + len_q))); // R5
    AST_FAIL_FROM_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        fail_pulse |-> $past(cmp_valid && cmp_fail)); // R7
endmodule

// File: tb/test_erase_range_walker.sv
`timescale 1ns/1ps
module test_erase_range_walker;
    localparam int AW = 8;
    localparam int B0 = 4, N0 = 4, B1 = 16, N1 = 3;
    localparam int BOUND = B0 * N0;
    localparam int TOTAL = BOUND + B1 * N1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, ers_ready = 1'b0, cmp_valid = 1'b0, cmp_fail = 1'b0;
    logic [AW-1:0] req_start = '0, req_len = '0;
    logic req_ready, ers_valid, done_pulse, invalid_pulse, fail_pulse;
    logic [AW-1:0] ers_addr;

    int n_tests = 0, n_fail = 0, cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    erase_range_walker #(
        .ADDR_W(AW), .R0_BLK(B0), .R0_NBLK(N0), .R1_BLK(B1), .R1_NBLK(N1)
    ) i_erase_range_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_start(req_start), .req_len(req_len),
        .ers_valid(ers_valid), .ers_ready(ers_ready), .ers_addr(ers_addr),
        .cmp_valid(cmp_valid), .cmp_fail(cmp_fail),
        .done_pulse(done_pulse), .invalid_pulse(invalid_pulse), .fail_pulse(fail_pulse)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // kind: 0 done, 1 invalid, 2 failed
    task automatic run_req(input int s, input int l, input int fail_at);
        int  exp_addr[$];
        int  kind_exp, n_exp, kind_got, seen, cd, k, lat;
        bit  busy_ok;
        int  e;
        string tag;
        int  bs, be;
        e  = s + l;
        bs = (s >= BOUND) ? B1 : B0;
        be = (e >= BOUND) ? B1 : B0;
        if (e > TOTAL) begin kind_exp = 1; tag = "R2"; end
        else if (s % bs != 0) begin kind_exp = 1; tag = "R3"; end
        else if (e % be != 0) begin kind_exp = 1; tag = "R4"; end
        else begin
            for (int a = s; a < e; a += ((a < BOUND) ? B0 : B1)) exp_addr.push_back(a);
            if (l == 0) begin kind_exp = 0; tag = "R9"; end
            else if (fail_at > 0 && fail_at <= exp_addr.size()) begin kind_exp = 2; tag = "R7"; end
            else begin kind_exp = 0; tag = "R8"; end
        end
        n_exp = (kind_exp == 1) ? 0 : ((kind_exp == 2) ? fail_at : exp_addr.size());

        @(negedge clk);
        check("R10", "req_ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_start = AW'(s); req_len = AW'(l);
        @(posedge clk);
        @(negedge clk);
        req_start = AW'(s + 1);  // busy-time offer must not be taken (R10)
        kind_got = -1; seen = 0; cd = -1; k = 0; lat = 0; busy_ok = 1'b1;
        forever begin
            k++;
            cmp_valid = 1'b0; cmp_fail = 1'b0;
            if (done_pulse || invalid_pulse || fail_pulse) begin
                kind_got = done_pulse ? 0 : (invalid_pulse ? 1 : 2);
                lat = k;
                req_valid = 1'b0;
                break;
            end
            if (req_ready) busy_ok = 1'b0;
            if (cd == 0) begin
                cmp_valid = 1'b1;
                cmp_fail  = (seen == fail_at);
                cd = -1;
            end else if (cd > 0) cd--;
            ers_ready = ((cyc % 3) != 1);
            if (ers_valid && !ers_ready) begin
                cmp_valid = 1'b1;  // stray failing completion, must be ignored (R6)
                cmp_fail  = 1'b1;
            end
            if (ers_valid && ers_ready) begin
                if (seen < exp_addr.size())
                    check("R5", "erase address", int'(ers_addr), exp_addr[seen]);
                seen++;
                cd = (s + l + seen) % 3;
            end
            if (k > 400) begin
                check(tag, "timeout waiting for result", 0, 1);
                req_valid = 1'b0;
                break;
            end
            @(negedge clk);
        end
        cmp_valid = 1'b0; cmp_fail = 1'b0;
        check(tag, "result kind", kind_got, kind_exp);
        check(tag, "erase command count", seen, n_exp);
        check("R10", "req_ready low while busy", int'(busy_ok), 1);
        if (kind_exp == 1 || l == 0)
            check("R10", "result latency", lat, 2);
    endtask

    initial begin
        #(8 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "req_ready after reset", int'(req_ready), 1);
        check("R11", "ers_valid after reset", int'(ers_valid), 0);
        check("R11", "result pulses after reset",
              int'({done_pulse, invalid_pulse, fail_pulse}), 0);

        // stray completion while idle (R6)
        cmp_valid = 1'b1; cmp_fail = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0; cmp_fail = 1'b0;
        @(negedge clk);
        check("R6", "stray completion while idle", int'({done_pulse, invalid_pulse, fail_pulse, ers_valid}), 0);

        // boundary-crossing range with failure on each block (R7), then clean (R8)
        for (int f = 0; f <= 3; f++) run_req(12, 20, f);
        run_req(0, TOTAL, 0);          // whole device (R1, R8)
        run_req(TOTAL - B1, B1, 0);    // ends on device end (R8)
        run_req(0, BOUND, 0);          // ends on region offset (R4, R8)
        run_req(TOTAL, 0, 0);          // empty at the end (R9)
        run_req(TOTAL + 4, 0, 0);      // empty beyond the end (R2, R9)

        // sweep every start and length of the small map
        for (int s = 0; s <= TOTAL + 4; s++)
            for (int l = 0; l <= TOTAL + 4; l++)
                run_req(s, l, ((s / 4) + l) % 5);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule